// File: doc/BRIEF.md
# Link Power State Manager

This block manages the interface power state of one serial ATA link on the host side. The link layer decodes incoming primitives and passes them in. When the attached device asks for a reduced-power state (Partial or Slumber), the block sends an acknowledge request to the link layer. It then moves the link into that state once the link is idle. The host never starts a power-down by itself.

When the transport logic raises a transfer request while the link is in Partial or Slumber, the block starts an out-of-band wake sequence. It holds the grant back until the wake handshake reports completion, and the link is then Ready again. A device-side wake returns the link to Ready without any host wake. If a host wake does not complete within the limit set for the state it started from, the link drops to a down state and a sticky error flag is raised. Both limits are parameters, sized so that a wake from Slumber can take up to 10 ms. The block runs only while the controller as a whole is fully powered.

Top module: `lpm_link_pwr`

## Requirements
- R1: After reset, `link_state_o` is 0 (Ready), and `send_ack_o`, `wake_req_o`, `xfer_gnt_o` and `wake_err_o` are all 0.
- R2: A primitive with `prim_valid_i`=1 and `prim_code_i` equal to 1 (Partial request) or 2 (Slumber request) makes `send_ack_o` high for exactly the next cycle, in every link state. Codes 0 and 3 produce no acknowledge.
- R3: In Ready with `xfer_req_i`=0, an acknowledged Partial request makes `link_state_o` equal 1 in the cycle after the acknowledge.
- R4: In Ready with `xfer_req_i`=0, an acknowledged Slumber request makes `link_state_o` equal 2 in the cycle after the acknowledge.
- R5: The link never leaves Ready for Partial or Slumber unless a device request is pending. With no requests, the state stays at 0.
- R6: A power-down request that arrives while a transfer is granted is still acknowledged. The state stays Ready with the grant held until `xfer_req_i` drops, and the state change follows in the next cycle.
- R7: `xfer_req_i` in Partial or Slumber moves the link to Waking (3) in the next cycle, with `wake_req_o`=1 and `xfer_gnt_o`=0. After `wake_done_i`, the link is Ready and `xfer_gnt_o` follows `xfer_req_i`. A grant is only ever given in Ready.
- R8: A host wake that started from Partial lasts at most `PARTIAL_WAKE_CYC` cycles, and one from Slumber at most `SLUMBER_WAKE_CYC` cycles. On expiry, `link_state_o` becomes 4 (Down), `wake_req_o` drops and `wake_err_o` is set. The error flag stays set until reset.
- R9: `dev_wake_i` in Partial or Slumber returns the link to Ready in the next cycle, and `wake_req_o` is never raised.
- R10: In Down, `xfer_gnt_o` stays 0. A `dev_wake_i` brings the link back to Ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_valid_i | input | 1 | Decoded primitive present this cycle |
| prim_code_i | input | 2 | Decoded primitive: 1 Partial request, 2 Slumber request, other codes ignored |
| send_ack_o | output | 1 | Request to the link layer to transmit an acknowledge primitive |
| wake_req_o | output | 1 | Host out-of-band wake sequence request |
| wake_done_i | input | 1 | Wake sequence completed, link is up |
| dev_wake_i | input | 1 | Wake sequence from the device detected |
| xfer_req_i | input | 1 | Transport logic wants to use the link |
| xfer_gnt_o | output | 1 | Transfer may proceed |
| link_state_o | output | 3 | 0 Ready, 1 Partial, 2 Slumber, 3 Waking, 4 Down |
| wake_err_o | output | 1 | Sticky wake timeout flag |

## Verification
The following are checked on every cycle:
- a grant is only given in Ready;
- a host wake only starts on a transfer request;
- Ready is only left for a low-power state while a device request is pending;
- every power-down request gets its acknowledge;
- a device wake returns the link to Ready without a host wake;
- the timeout counter stays inside its limit;
- the error flag stays set once raised.

Only the bench scenarios show the rest:
- the exact cycle at which each state change happens;
- that Partial and Slumber use different wake limits;
- that a request arriving during a transfer is deferred rather than dropped;
- the recovery path out of Down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_READY   = 3'd0,
    ST_PARTIAL = 3'd1,
    ST_SLUMBER = 3'd2,
    ST_WAKING  = 3'd3,
    ST_DOWN    = 3'd4
  } lpm_state_e;

  localparam int unsigned PRIM_W = 2;

  localparam logic [PRIM_W-1:0] PRIM_NONE    = 2'd0;
  localparam logic [PRIM_W-1:0] PRIM_PARTIAL = 2'd1;
  localparam logic [PRIM_W-1:0] PRIM_SLUMBER = 2'd2;
  localparam logic [PRIM_W-1:0] PRIM_OTHER   = 2'd3;

endpackage

// File: rtl/lpm_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpm_req_tracker.sv
// Acknowledges device power-down requests and holds the latest one
// until the state machine can act on it.
module lpm_req_tracker
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prim_valid_i,
  input  logic [PRIM_W-1:0] prim_code_i,
  input  logic              take_i,
  input  logic              drop_i,
  output logic              pend_vld_o,
  output logic              pend_slumber_o,
  output logic              ack_o
);

  logic is_pm;
  logic vld_q, vld_d;
  logic slm_q, slm_d;
  logic ack_q;

  assign is_pm = prim_valid_i &&
                 ((prim_code_i == PRIM_PARTIAL) || (prim_code_i == PRIM_SLUMBER));

  always_comb begin
    vld_d = vld_q;
    slm_d = slm_q;
    if (take_i || drop_i) begin
      vld_d = 1'b0;
    end
    // A fresh request overrides one being consumed in the same cycle.
    if (is_pm) begin
      vld_d = 1'b1;
      slm_d = (prim_code_i == PRIM_SLUMBER);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      slm_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      slm_q <= slm_d;
      ack_q <= is_pm;
    end
  end

  assign pend_vld_o     = vld_q;
  assign pend_slumber_o = slm_q;
  assign ack_o          = ack_q;

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> vld_q) else $error("take without pending request"); // R5

endmodule

// File: rtl/lpm_wake_timer.sv
// Counts cycles spent waiting for a host wake; the limit depends on
// the low-power state the wake started from.
module lpm_wake_timer #(
  parameter int unsigned PARTIAL_WAKE_CYC = 64,
  parameter int unsigned SLUMBER_WAKE_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic from_slumber_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned MAX_CYC = (SLUMBER_WAKE_CYC > PARTIAL_WAKE_CYC) ?
                                    SLUMBER_WAKE_CYC : PARTIAL_WAKE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PARTIAL_WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SLUMBER_WAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             sel_q, sel_d;
  logic             sel_en;
  logic [CNT_W-1:0] last;

  assign last     = sel_q ? S_LAST : P_LAST;
  assign expire_o = run_i && (cnt_q == last);

  assign cnt_en = start_i || run_i;
  assign sel_en = start_i;

  always_comb begin
    if (start_i) begin
      cnt_d = '0;
    end else if (cnt_q != last) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    sel_d = from_slumber_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= last)) else $error("wake counter past limit"); // R8

endmodule

// File: rtl/lpm_state_fsm.sv
// Link power state machine: follows device requests, wakes on demand.
module lpm_state_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_vld_i,
  input  logic       pend_slumber_i,
  input  logic       xfer_req_i,
  input  logic       dev_wake_i,
  input  logic       wake_done_i,
  input  logic       tmo_i,
  output lpm_state_e st_o,
  output logic       take_o,
  output logic       drop_o,
  output logic       wake_start_o,
  output logic       wake_from_slm_o,
  output logic       err_o
);

  lpm_state_e st_q, st_d;
  logic       err_q, err_d;

  always_comb begin
    st_d            = st_q;
    err_d           = err_q;
    take_o          = 1'b0;
    drop_o          = 1'b0;
    wake_start_o    = 1'b0;
    wake_from_slm_o = 1'b0;
    unique case (st_q)
      ST_READY: begin
        if (pend_vld_i && !xfer_req_i) begin
          take_o = 1'b1;
          st_d   = pend_slumber_i ? ST_SLUMBER : ST_PARTIAL;
        end
      end
      ST_PARTIAL, ST_SLUMBER: begin
        if (dev_wake_i) begin
          drop_o = 1'b1;
          st_d   = ST_READY;
        end else if (xfer_req_i) begin
          wake_start_o    = 1'b1;
          wake_from_slm_o = (st_q == ST_SLUMBER);
          st_d            = ST_WAKING;
        end else if (pend_vld_i) begin
          take_o = 1'b1;
          st_d   = pend_slumber_i ? ST_SLUMBER : ST_PARTIAL;
        end
      end
      ST_WAKING: begin
        if (wake_done_i || dev_wake_i) begin
          st_d = ST_READY;
        end else if (tmo_i) begin
          st_d  = ST_DOWN;
          err_d = 1'b1;
        end
      end
      ST_DOWN: begin
        if (dev_wake_i) begin
          st_d = ST_READY;
        end
      end
      default: st_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_READY;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign st_o  = st_q;
  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q) else $error("error flag cleared"); // R8

  AST_DEV_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PARTIAL || st_q == ST_SLUMBER) && dev_wake_i) |=> (st_q == ST_READY))
    else $error("device wake did not reach Ready"); // R9

endmodule

// File: rtl/lpm_link_pwr.sv
module lpm_link_pwr
  import lpm_pkg::*;
#(
  parameter int unsigned PARTIAL_WAKE_CYC = 64,
  parameter int unsigned SLUMBER_WAKE_CYC = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prim_valid_i,
  input  logic [1:0] prim_code_i,
  output logic       send_ack_o,
  output logic       wake_req_o,
  input  logic       wake_done_i,
  input  logic       dev_wake_i,
  input  logic       xfer_req_i,
  output logic       xfer_gnt_o,
  output logic [2:0] link_state_o,
  output logic       wake_err_o
);

  logic       rst_int_n;
  logic       pend_vld, pend_slm;
  logic       take, drop;
  logic       wake_start, wake_from_slm;
  logic       tmo;
  lpm_state_e st;

  lpm_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpm_req_tracker req_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .prim_valid_i   (prim_valid_i),
    .prim_code_i    (prim_code_i),
    .take_i         (take),
    .drop_i         (drop),
    .pend_vld_o     (pend_vld),
    .pend_slumber_o (pend_slm),
    .ack_o          (send_ack_o)
  );

  lpm_wake_timer #(
    .PARTIAL_WAKE_CYC (PARTIAL_WAKE_CYC),
    .SLUMBER_WAKE_CYC (SLUMBER_WAKE_CYC)
  ) tmr_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .start_i        (wake_start),
    .from_slumber_i (wake_from_slm),
    .run_i          (st == ST_WAKING),
    .expire_o       (tmo)
  );

  lpm_state_fsm fsm_i (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .pend_vld_i      (pend_vld),
    .pend_slumber_i  (pend_slm),
    .xfer_req_i      (xfer_req_i),
    .dev_wake_i      (dev_wake_i),
    .wake_done_i     (wake_done_i),
    .tmo_i           (tmo),
    .st_o            (st),
    .take_o          (take),
    .drop_o          (drop),
    .wake_start_o    (wake_start),
    .wake_from_slm_o (wake_from_slm),
    .err_o           (wake_err_o)
  );

  assign wake_req_o   = (st == ST_WAKING);
  assign xfer_gnt_o   = (st == ST_READY) && xfer_req_i;
  assign link_state_o = st;

  AST_ACK_EVERY_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prim_valid_i && (prim_code_i == PRIM_PARTIAL || prim_code_i == PRIM_SLUMBER))
    |=> send_ack_o) else $error("request not acknowledged"); // R2

  AST_GNT_IN_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer_gnt_o |-> (link_state_o == 3'd0)) else $error("grant outside Ready"); // R7

  AST_WAKE_ON_DEMAND: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wake_req_o) |-> $past(xfer_req_i)) else $error("wake without demand"); // R7

  AST_NO_HOST_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st == ST_PARTIAL || st == ST_SLUMBER) && $past(st) == ST_READY) |-> $past(pend_vld))
    else $error("power-down without device request"); // R5

  AST_DEV_WAKE_NO_HOST: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st == ST_PARTIAL || st == ST_SLUMBER) && dev_wake_i) |=> !wake_req_o)
    else $error("host wake after device wake"); // R9

endmodule

// File: tb/lpm_link_pwr_tb_top.sv
module lpm_link_pwr_tb_top;

  localparam int unsigned P_CYC = 20;
  localparam int unsigned S_CYC = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       prim_valid_i;
  logic [1:0] prim_code_i;
  logic       send_ack_o;
  logic       wake_req_o;
  logic       wake_done_i;
  logic       dev_wake_i;
  logic       xfer_req_i;
  logic       xfer_gnt_o;
  logic [2:0] link_state_o;
  logic       wake_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpm_link_pwr #(
    .PARTIAL_WAKE_CYC (P_CYC),
    .SLUMBER_WAKE_CYC (S_CYC)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .prim_valid_i (prim_valid_i),
    .prim_code_i  (prim_code_i),
    .send_ack_o   (send_ack_o),
    .wake_req_o   (wake_req_o),
    .wake_done_i  (wake_done_i),
    .dev_wake_i   (dev_wake_i),
    .xfer_req_i   (xfer_req_i),
    .xfer_gnt_o   (xfer_gnt_o),
    .link_state_o (link_state_o),
    .wake_err_o   (wake_err_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    prim_valid_i = 1'b0; prim_code_i = 2'd0;
    wake_done_i = 1'b0; dev_wake_i = 1'b0; xfer_req_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic send_prim(logic [1:0] code);
    prim_valid_i = 1'b1; prim_code_i = code;
    tick();
    prim_valid_i = 1'b0; prim_code_i = 2'd0;
  endtask

  task automatic t_reset_state();
    chk("R1", "state", link_state_o, 0);
    chk("R1", "ack", send_ack_o, 0);
    chk("R1", "wake_req", wake_req_o, 0);
    chk("R1", "gnt", xfer_gnt_o, 0);
    chk("R1", "err", wake_err_o, 0);
  endtask

  task automatic t_idle_stays_ready();
    send_prim(2'd0);
    chk("R2", "ack code0", send_ack_o, 0);
    send_prim(2'd3);
    chk("R2", "ack code3", send_ack_o, 0);
    repeat (40) tick();
    chk("R5", "idle state", link_state_o, 0);
  endtask

  task automatic t_partial_entry();
    send_prim(2'd1);
    chk("R2", "ack partial", send_ack_o, 1);
    chk("R3", "state before", link_state_o, 0);
    tick();
    chk("R2", "ack one cycle", send_ack_o, 0);
    chk("R3", "state partial", link_state_o, 1);
  endtask

  task automatic t_host_wake();
    xfer_req_i = 1'b1;
    tick();
    chk("R7", "waking", link_state_o, 3);
    chk("R7", "wake_req", wake_req_o, 1);
    chk("R7", "gnt held", xfer_gnt_o, 0);
    repeat (3) tick();
    chk("R7", "gnt still held", xfer_gnt_o, 0);
    wake_done_i = 1'b1;
    tick();
    wake_done_i = 1'b0;
    chk("R7", "ready", link_state_o, 0);
    chk("R7", "wake_req off", wake_req_o, 0);
    chk("R7", "gnt", xfer_gnt_o, 1);
  endtask

  task automatic t_req_during_xfer();
    send_prim(2'd2);
    chk("R6", "ack in xfer", send_ack_o, 1);
    tick();
    chk("R6", "stay ready", link_state_o, 0);
    chk("R6", "gnt kept", xfer_gnt_o, 1);
    tick();
    chk("R6", "still ready", link_state_o, 0);
    xfer_req_i = 1'b0;
    tick();
    chk("R4", "slumber", link_state_o, 2);
  endtask

  task automatic t_dev_wake();
    dev_wake_i = 1'b1;
    tick();
    dev_wake_i = 1'b0;
    chk("R9", "ready", link_state_o, 0);
    chk("R9", "no host wake", wake_req_o, 0);
    repeat (3) tick();
    chk("R9", "stay ready", link_state_o, 0);
  endtask

  task automatic t_partial_timeout();
    send_prim(2'd1);
    tick();
    chk("R3", "partial", link_state_o, 1);
    xfer_req_i = 1'b1;
    tick();
    repeat (P_CYC - 1) tick();
    chk("R8", "partial still waking", link_state_o, 3);
    tick();
    chk("R8", "down", link_state_o, 4);
    chk("R8", "err", wake_err_o, 1);
    chk("R8", "wake_req off", wake_req_o, 0);
    chk("R10", "no gnt", xfer_gnt_o, 0);
    wake_done_i = 1'b1;
    tick();
    wake_done_i = 1'b0;
    chk("R10", "done ignored", link_state_o, 4);
    dev_wake_i = 1'b1;
    tick();
    dev_wake_i = 1'b0;
    chk("R10", "ready", link_state_o, 0);
    chk("R10", "gnt", xfer_gnt_o, 1);
    chk("R8", "err sticky", wake_err_o, 1);
    xfer_req_i = 1'b0;
  endtask

  task automatic t_slumber_timeout();
    send_prim(2'd2);
    tick();
    chk("R4", "slumber", link_state_o, 2);
    xfer_req_i = 1'b1;
    tick();
    repeat (P_CYC + 5) tick();
    chk("R8", "slumber limit longer", link_state_o, 3);
    repeat (S_CYC - P_CYC - 6) tick();
    chk("R8", "slumber last cycle", link_state_o, 3);
    tick();
    chk("R8", "slumber down", link_state_o, 4);
    chk("R8", "slumber err", wake_err_o, 1);
    xfer_req_i = 1'b0;
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_idle_stays_ready();
    t_partial_entry();
    t_host_wake();
    t_req_during_xfer();
    t_dev_wake();
    t_partial_timeout();
    do_reset();
    t_reset_state();
    t_slumber_timeout();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule